// File: doc/BRIEF.md
# Indirect Configuration, I/O-Port and Memory Access Window

This block is a host-facing register front-end for a downstream expansion bus. The host cannot address the downstream bus directly. It loads a target address into an address register and then reads or writes one of three data windows. The window it touches selects the downstream cycle type: configuration, I/O port or memory. Each data-window access produces one downstream request carrying the cycle type, a full 32-bit address, byte enables, lane-placed write data and the direction. The read data that comes back is handed to the host right-aligned.

Configuration addresses are packed as bus number, device/function and register offset. I/O-port accesses use the low 16 bits of the address register. Memory accesses go through one 8 MB slice of a fixed region, and a one-hot enable register picks that slice. The host may access bytes, halfwords or words. The low host address bits choose the lanes on the little-endian downstream bus.

The host side is a valid/ready handshake. While `h_valid` is high and `h_ready` is low, the host must hold address, size, direction and write data stable. An access completes in the cycle where both are high, and read data is valid in that cycle. Register and unmapped accesses complete in their first cycle. A data-window access stalls until the downstream side acknowledges and completes in the cycle after the acknowledge. The downstream request is also valid/ready. `d_valid` and every request field stay stable until `d_ready` is seen high.

Top module: `indirect_access_window`

## Requirements
- R1: After reset, `d_valid` is low and both the address register and the window-enable register read as zero.
- R2: Host word offset 0x064 is the read/write address register and 0x060 is the read/write window-enable register. A byte or halfword write updates only the addressed lanes, and reads return the addressed lanes right-aligned.
- R3: An access to the configuration window (0x068) issues a request of type 0 whose address is {8'h00, addr_reg[23:2], 2'b00}. Bits 23:16 carry the bus number, 15:8 the device/function and 7:0 the word-aligned register offset.
- R4: An access to the I/O window (0x06C) issues a request of type 1 whose address is {16'h0000, addr_reg[15:2], 2'b00}. The window-enable register has no effect on it.
- R5: An access to the memory window (0x070) issues a request of type 2 whose address is 0xF0000000 + i×0x800000 + (addr_reg & 0x007FFFFC). Here i is the lowest set bit of the window-enable register among bits 1 to 30.
- R6: When no window-enable bit in the range 1 to 30 is set, a memory-window access issues no request, completes at once and reads zero. Bits 0 and 31 are ignored.
- R7: Host size 0 is byte, 1 is halfword, and 2 or 3 is word. Byte enables are 1<<addr[1:0] for a byte, 4'b0011<<(2×addr[1]) for a halfword and 4'b1111 for a word. Right-aligned host write data is moved into the selected lanes, with lane k at bits 8k+7:8k and the other lanes zero. Read requests carry zero write data.
- R8: Read data returns to the host right-aligned: the selected byte or halfword is taken from the downstream word, and the upper bits are zero.
- R9: A downstream request holds all its fields until acknowledged. `h_ready` stays low while the request is pending and rises in the cycle after `d_valid && d_ready`.
- R10: Accesses to any other offset complete at once, read zero, change no register and issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Host access completes this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 12 | Host byte address within the register page |
| h_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| h_wdata | input | 32 | Right-aligned host write data |
| h_rdata | output | 32 | Right-aligned read data, valid with h_ready |
| d_valid | output | 1 | Downstream request pending |
| d_ready | input | 1 | Downstream acknowledge |
| d_type | output | 2 | Cycle type: 0 config, 1 I/O, 2 memory |
| d_write | output | 1 | Request direction, 1 = write |
| d_addr | output | 32 | Word-aligned downstream address |
| d_be | output | 4 | Byte enables, bit k = lane k |
| d_wdata | output | 32 | Lane-placed write data |
| d_rdata | input | 32 | Downstream read word, taken with d_ready |

## Verification
The hardest conditions to reach from the ports are in the memory window. One is an enable register with several bits set, where the lowest bit must win. Another is an enable register whose only set bits lie outside the valid range, so the window must act as disabled. The stimulus reaches both by rewriting the enable register through full-word and single-byte writes between memory accesses, including a byte write that adds a lower bit to an existing upper bit. Lasting back-pressure is the other hard case. A directed access holds the acknowledge off for several cycles and checks on every waiting cycle that the request is unchanged and the host stays stalled.

// File: rtl/iaw_pkg.sv
package iaw_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    CYC_CFG = 2'd0,
    CYC_IO  = 2'd1,
    CYC_MEM = 2'd2
  } cyc_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DONE
  } st_t;
endpackage

// File: rtl/iaw_lane_steer.sv
module iaw_lane_steer
  import iaw_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        lane,
  input  logic [DATA_W-1:0] wdata_ra,
  input  logic [DATA_W-1:0] rword,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_ln,
  output logic [DATA_W-1:0] rdata_ra
);
  logic [4:0] bsh;
  logic [4:0] hsh;

  assign bsh = {lane, 3'b000};
  assign hsh = {lane[1], 4'b0000};

  always_comb begin
    unique case (size)
      2'd0: begin
        be       = 4'b0001 << lane;
        wdata_ln = {24'h0, wdata_ra[7:0]} << bsh;
        rdata_ra = (rword >> bsh) & 32'h0000_00FF;
      end
      2'd1: begin
        be       = 4'b0011 << {lane[1], 1'b0};
        wdata_ln = {16'h0, wdata_ra[15:0]} << hsh;
        rdata_ra = (rword >> hsh) & 32'h0000_FFFF;
      end
      default: begin
        be       = 4'b1111;
        wdata_ln = wdata_ra;
        rdata_ra = rword;
      end
    endcase
  end
endmodule

// File: rtl/iaw_win_decode.sv
module iaw_win_decode #(
  parameter int EN_W   = 32,
  parameter int LO_BIT = 1,
  parameter int HI_BIT = 30,
  localparam int IDX_W = $clog2(EN_W)
) (
  input  logic [EN_W-1:0]  en,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    // descending scan so the lowest qualifying bit is applied last
    for (int i = EN_W - 1; i >= 0; i--) begin
      if (en[i] && i >= LO_BIT && i <= HI_BIT) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/iaw_addr_form.sv
module iaw_addr_form
  import iaw_pkg::*;
#(
  parameter int          IDX_W    = 5,
  parameter int          SLICE_SH = 23,
  parameter logic [31:0] WIN_BASE = 32'hF000_0000,
  localparam logic [31:0] OFF_MASK = ((32'd1 << SLICE_SH) - 32'd1) & ~32'd3
) (
  input  logic [31:0]      areg,
  input  cyc_t             cyc,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      addr
);
  logic [31:0] slice_base;

  assign slice_base = WIN_BASE + ({{(32-IDX_W){1'b0}}, idx} << SLICE_SH);

  always_comb begin
    unique case (cyc)
      CYC_CFG: addr = {8'h00, areg[23:2], 2'b00};
      CYC_IO:  addr = {16'h0000, areg[15:2], 2'b00};
      default: addr = slice_base + (areg & OFF_MASK);
    endcase
  end
endmodule

// File: rtl/indirect_access_window.sv
module indirect_access_window
  import iaw_pkg::*;
#(
  parameter int           AW       = 12,
  parameter logic [11:0]  OFF_WEN  = 12'h060,
  parameter logic [11:0]  OFF_ADDR = 12'h064,
  parameter logic [11:0]  OFF_CFG  = 12'h068,
  parameter logic [11:0]  OFF_IO   = 12'h06C,
  parameter logic [11:0]  OFF_MEM  = 12'h070,
  parameter int           WIN_LO   = 1,
  parameter int           WIN_HI   = 30,
  parameter int           SLICE_SH = 23,
  parameter logic [31:0]  WIN_BASE = 32'hF000_0000,
  localparam int          IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [AW-1:0]     h_addr,
  input  logic [1:0]        h_size,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              d_valid,
  input  logic              d_ready,
  output logic [1:0]        d_type,
  output logic              d_write,
  output logic [31:0]       d_addr,
  output logic [3:0]        d_be,
  output logic [31:0]       d_wdata,
  input  logic [31:0]       d_rdata
);
  st_t               state_q;
  logic [31:0]       areg_q, wen_q, rbuf_q;
  logic              dv_q, dw_q;
  cyc_t              dt_q;
  logic [31:0]       da_q, dd_q;
  logic [LANES-1:0]  db_q;

  // ---- offset decode ----
  logic [AW-1:0] woff;
  logic sel_wen, sel_addr, sel_cfg, sel_io, sel_mem;
  assign woff     = {h_addr[AW-1:2], 2'b00};
  assign sel_wen  = (woff == OFF_WEN[AW-1:0]);
  assign sel_addr = (woff == OFF_ADDR[AW-1:0]);
  assign sel_cfg  = (woff == OFF_CFG[AW-1:0]);
  assign sel_io   = (woff == OFF_IO[AW-1:0]);
  assign sel_mem  = (woff == OFF_MEM[AW-1:0]);

  // ---- memory window selection ----
  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  iaw_win_decode #(.EN_W(DATA_W), .LO_BIT(WIN_LO), .HI_BIT(WIN_HI)) u_win (
    .en(wen_q), .hit(win_hit), .idx(win_idx)
  );

  // ---- cycle type and downstream address ----
  cyc_t        cyc;
  logic [31:0] addr_nx;
  assign cyc = sel_cfg ? CYC_CFG : (sel_io ? CYC_IO : CYC_MEM);
  iaw_addr_form #(.IDX_W(IDX_W), .SLICE_SH(SLICE_SH), .WIN_BASE(WIN_BASE)) u_af (
    .areg(areg_q), .cyc(cyc), .idx(win_idx), .addr(addr_nx)
  );

  // ---- lane steering, shared by register and window paths ----
  logic [31:0]      rsrc, wl, rra;
  logic [LANES-1:0] be;
  logic [31:0]      bemask;
  always_comb begin
    if (state_q == ST_DONE) rsrc = rbuf_q;
    else if (sel_addr)      rsrc = areg_q;
    else if (sel_wen)       rsrc = wen_q;
    else                    rsrc = '0;
  end
  iaw_lane_steer u_ls (
    .size(h_size), .lane(h_addr[1:0]), .wdata_ra(h_wdata), .rword(rsrc),
    .be(be), .wdata_ln(wl), .rdata_ra(rra)
  );
  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign bemask[8*k +: 8] = {8{be[k]}};
  end

  // ---- handshake ----
  logic need_dn, reg_wr;
  assign need_dn = h_valid && (sel_cfg || sel_io || (sel_mem && win_hit));
  assign h_ready = (state_q == ST_DONE) || (state_q == ST_IDLE && !need_dn);
  assign h_rdata = h_write ? 32'h0 : rra;
  assign reg_wr  = (state_q == ST_IDLE) && h_valid && h_write && !need_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      areg_q  <= '0;
      wen_q   <= '0;
      rbuf_q  <= '0;
      dv_q    <= 1'b0;
      dw_q    <= 1'b0;
      dt_q    <= CYC_CFG;
      da_q    <= '0;
      dd_q    <= '0;
      db_q    <= '0;
    end else begin
      if (reg_wr && sel_addr) areg_q <= (areg_q & ~bemask) | (wl & bemask);
      if (reg_wr && sel_wen)  wen_q  <= (wen_q  & ~bemask) | (wl & bemask);
      unique case (state_q)
        ST_IDLE: if (need_dn) begin
          state_q <= ST_REQ;
          dv_q    <= 1'b1;
          dw_q    <= h_write;
          dt_q    <= cyc;
          da_q    <= addr_nx;
          db_q    <= be;
          dd_q    <= h_write ? wl : 32'h0;
        end
        ST_REQ: if (d_ready) begin
          state_q <= ST_DONE;
          dv_q    <= 1'b0;
          rbuf_q  <= d_rdata;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign d_valid = dv_q;
  assign d_write = dw_q;
  assign d_type  = dt_q;
  assign d_addr  = da_q;
  assign d_be    = db_q;
  assign d_wdata = dd_q;

  // ---- assertions ----
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !d_ready |=> d_valid && $stable(d_addr) && $stable(d_be)
                            && $stable(d_type) && $stable(d_wdata) && $stable(d_write))
    else $error("request changed before acknowledge");
  // R9
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && d_ready |=> h_ready && !d_valid)
    else $error("host not released after acknowledge");
  // R7
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> d_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF})
    else $error("illegal byte enable pattern");
  // R3
  cfg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && d_type == 2'd0 |-> d_addr[31:24] == 8'h0 && d_addr[1:0] == 2'b00)
    else $error("config address out of token range");
  // R4
  io_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && d_type == 2'd1 |-> d_addr[31:16] == 16'h0 && d_addr[1:0] == 2'b00)
    else $error("I/O address wider than port space");
  // R5
  mem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && d_type == 2'd2 |-> d_addr >= WIN_BASE)
    else $error("memory address below window region");
  // R6
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !d_valid && !need_dn |=> !d_valid)
    else $error("request issued without a window access");
endmodule

// File: tb/indirect_access_window_tb.sv
`timescale 1ns/1ps
module indirect_access_window_tb;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic [11:0] h_addr = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic        d_valid, d_write;
  logic        d_ready = 1'b0;
  logic [1:0]  d_type;
  logic [31:0] d_addr, d_wdata;
  logic [3:0]  d_be;
  logic [31:0] d_rdata = '0;

  always #(HALF) clk = ~clk;

  indirect_access_window u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_valid(d_valid), .d_ready(d_ready), .d_type(d_type), .d_write(d_write),
    .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_rdata(d_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // observations of one access
  logic        got_req, timed_out, stall_bad;
  logic [1:0]  o_type;
  logic        o_wr;
  logic [31:0] o_addr, o_wd, o_rd;
  logic [3:0]  o_be;

  task automatic do_acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] resp, input int lat);
    int waitc = 0;
    got_req = 0; timed_out = 1; stall_bad = 0; o_rd = '0;
    @(negedge clk);
    h_valid = 1; h_write = wr; h_addr = a; h_size = sz; h_wdata = wd;
    for (int k = 0; k < 64; k++) begin
      #1;
      if (h_ready) begin
        o_rd = h_rdata; timed_out = 0;
        break;
      end
      if (d_valid && !d_ready) begin
        if (!got_req) begin
          got_req = 1; o_type = d_type; o_wr = d_write;
          o_addr = d_addr; o_be = d_be; o_wd = d_wdata;
        end else if (d_addr !== o_addr || d_be !== o_be || d_wdata !== o_wd) begin
          stall_bad = 1;
        end
        if (waitc >= lat) begin
          d_ready = 1; d_rdata = resp;
        end else begin
          waitc++;
        end
      end else begin
        d_ready = 0;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    h_valid = 0; d_ready = 0; h_wdata = '0;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [11:0] a;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] resp;
    logic        rq;
    logic [1:0]  ty;
    logic [31:0] da;
    logic [3:0]  be;
    logic [31:0] dw;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 36;
  // size: 0 byte, 1 half, 2 word; type: 0 cfg, 1 io, 2 mem
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1, 12'h064, 2'd2, 32'h00123A0E, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd2, 1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h00123A0E},
    '{4'd3, 1'b0, 12'h068, 2'd2, 32'h0, 32'h11223344, 1'b1, 2'd0, 32'h00123A0C, 4'hF, 32'h0, 32'h11223344},
    '{4'd8, 1'b0, 12'h06A, 2'd0, 32'h0, 32'h11223344, 1'b1, 2'd0, 32'h00123A0C, 4'h4, 32'h0, 32'h00000022},
    '{4'd8, 1'b0, 12'h06A, 2'd1, 32'h0, 32'h11223344, 1'b1, 2'd0, 32'h00123A0C, 4'hC, 32'h0, 32'h00001122},
    '{4'd8, 1'b0, 12'h069, 2'd0, 32'h0, 32'h11223344, 1'b1, 2'd0, 32'h00123A0C, 4'h2, 32'h0, 32'h00000033},
    '{4'd7, 1'b1, 12'h069, 2'd0, 32'h000000A5, 32'h0, 1'b1, 2'd0, 32'h00123A0C, 4'h2, 32'h0000A500, 32'h0},
    '{4'd7, 1'b1, 12'h06A, 2'd1, 32'h0000BEEF, 32'h0, 1'b1, 2'd0, 32'h00123A0C, 4'hC, 32'hBEEF0000, 32'h0},
    '{4'd7, 1'b1, 12'h068, 2'd2, 32'hDEADBEEF, 32'h0, 1'b1, 2'd0, 32'h00123A0C, 4'hF, 32'hDEADBEEF, 32'h0},
    '{4'd4, 1'b1, 12'h064, 2'd2, 32'h000003F9, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd4, 1'b0, 12'h06D, 2'd0, 32'h0, 32'h00007700, 1'b1, 2'd1, 32'h000003F8, 4'h2, 32'h0, 32'h00000077},
    '{4'd4, 1'b1, 12'h06C, 2'd2, 32'h12345678, 32'h0, 1'b1, 2'd1, 32'h000003F8, 4'hF, 32'h12345678, 32'h0},
    '{4'd6, 1'b0, 12'h070, 2'd2, 32'h0, 32'h55555555, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd2, 1'b1, 12'h060, 2'd2, 32'h00000008, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd2, 1'b0, 12'h060, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h00000008},
    '{4'd2, 1'b1, 12'h064, 2'd2, 32'h00123454, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd5, 1'b0, 12'h070, 2'd2, 32'h0, 32'hCAFEF00D, 1'b1, 2'd2, 32'hF1923454, 4'hF, 32'h0, 32'hCAFEF00D},
    '{4'd4, 1'b0, 12'h06C, 2'd1, 32'h0, 32'h0000ABCD, 1'b1, 2'd1, 32'h00003454, 4'h3, 32'h0, 32'h0000ABCD},
    '{4'd5, 1'b1, 12'h060, 2'd2, 32'h00000006, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd5, 1'b0, 12'h072, 2'd1, 32'h0, 32'hCAFEF00D, 1'b1, 2'd2, 32'hF0923454, 4'hC, 32'h0, 32'h0000CAFE},
    '{4'd6, 1'b1, 12'h060, 2'd2, 32'h80000001, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd6, 1'b0, 12'h070, 2'd2, 32'h0, 32'h12121212, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd10, 1'b1, 12'h050, 2'd2, 32'h00005555, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd10, 1'b0, 12'h050, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd10, 1'b1, 12'h074, 2'd2, 32'hFFFFFFFF, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd10, 1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h00123454},
    '{4'd2, 1'b1, 12'h067, 2'd0, 32'h0000007E, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd2, 1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h7E123454},
    '{4'd2, 1'b0, 12'h066, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h00007E12},
    '{4'd3, 1'b0, 12'h068, 2'd2, 32'h0, 32'h0, 1'b1, 2'd0, 32'h00123454, 4'hF, 32'h0, 32'h0},
    '{4'd4, 1'b0, 12'h06C, 2'd2, 32'h0, 32'h0, 1'b1, 2'd1, 32'h00003454, 4'hF, 32'h0, 32'h0},
    '{4'd5, 1'b1, 12'h060, 2'd2, 32'h40000000, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd5, 1'b1, 12'h073, 2'd0, 32'h0000009C, 32'h0, 1'b1, 2'd2, 32'hFF123454, 4'h8, 32'h9C000000, 32'h0},
    '{4'd5, 1'b1, 12'h061, 2'd0, 32'h00000001, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h0},
    '{4'd5, 1'b0, 12'h070, 2'd2, 32'h0, 32'h0, 1'b1, 2'd2, 32'hF4123454, 4'hF, 32'h0, 32'h0},
    '{4'd2, 1'b0, 12'h060, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, 4'h0, 32'h0, 32'h40000100}
  };

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    string tg;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    @(negedge clk); #1;
    check("R1 d_valid after reset", {31'h0, d_valid}, 32'h0);
    do_acc(1'b0, 12'h064, 2'd2, '0, '0, 0);
    check("R1 address register reset", o_rd, 32'h0);
    do_acc(1'b0, 12'h060, 2'd2, '0, '0, 0);
    check("R1 enable register reset", o_rd, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      do_acc(VECS[v].wr, VECS[v].a, VECS[v].sz, VECS[v].wd, VECS[v].resp, 0);
      tg = $sformatf("R%0d vec%0d", VECS[v].req, v);
      check({tg, " timeout"}, {31'h0, timed_out}, 32'h0);
      check({tg, " request issued"}, {31'h0, got_req}, {31'h0, VECS[v].rq});
      if (VECS[v].rq && got_req) begin
        check({tg, " type"}, {30'h0, o_type}, {30'h0, VECS[v].ty});
        check({tg, " dir"}, {31'h0, o_wr}, {31'h0, VECS[v].wr});
        check({tg, " addr"}, o_addr, VECS[v].da);
        check({tg, " be"}, {28'h0, o_be}, {28'h0, VECS[v].be});
        check({tg, " wdata"}, o_wd, VECS[v].dw);
      end
      check({tg, " rdata"}, o_rd, VECS[v].rd);
    end

    // R9: prolonged back-pressure on a config read
    do_acc(1'b0, 12'h06B, 2'd0, '0, 32'hA1B2C3D4, 4);
    check("R9 request stable while stalled", {31'h0, stall_bad}, 32'h0);
    check("R9 request issued", {31'h0, got_req}, 32'h1);
    check("R9 completion", {31'h0, timed_out}, 32'h0);
    check("R9 rdata after stall", o_rd, 32'h000000A1);

    // R1: reset clears registers again
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    do_acc(1'b0, 12'h064, 2'd2, '0, '0, 0);
    check("R1 address register after second reset", o_rd, 32'h0);
    do_acc(1'b0, 12'h070, 2'd2, '0, 32'h99999999, 0);
    check("R6 memory window disabled after reset", {31'h0, got_req}, 32'h0);

    finish_run();
  end
endmodule